// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Chain

This block holds the digital counters of a frequency synthesizer's phase-locked loop. The feedback path runs at the rate of an external dual-modulus prescaler. Two programmable counters, A and B, advance together on every prescaler output pulse. While A is still below its limit, the block asks the prescaler to divide by P+1. Once A is full, it asks for divide-by-P, and B runs on alone until it wraps. One full feedback cycle therefore covers P*B + A input cycles. A second counter divides down a reference tick stream.

The two divided pulse streams drive a tri-state phase-frequency detector. Its pump outputs follow a programmable polarity.

All limits and modes are written through a three-wire serial port with a shift clock, a data line and a latch strobe. The port shares the system clock domain: the block samples its pins once per clock and acts on their rising edges. The prescaler itself, the charge pump, the loop filter and the oscillator are outside the block. The prescaler's output and the reference are presented as one-clock enable ticks. The chosen base modulus and the pump current code are driven out to the analog side.

Top module: `pswl_synth_div`

## Requirements
- R1: After reset the settings are R=1, A=0, B=1, base modulus 16, pump current code 0 and positive polarity. All pulse, pump, modulus and error outputs are low.
- R2: A serial word is 21 bits, shifted in MSB first on rising edges of `ser_clk`. Bits [20:19] select the target: 00 is the reference limit, 01 is the feedback counts, 10 is control, and 11 is discarded with no effect on any setting. The new value is applied when `ser_le` rises.
- R3: In a feedback word, B is held in bits [18:6] and A in bits [5:0]. A word with A > B or B = 0 is refused: the old A and B stay in force and `n_load_err` goes high. A later accepted feedback word clears `n_load_err`.
- R4: In a control word, bit 0 selects the base modulus (0 selects 16 and is shown as `presc_hi`=0; 1 selects 32 and is shown as `presc_hi`=1). Bits [2:1] form the pump current code on `pump_level`. Bit 3 selects positive polarity when it is 1.
- R5: In every feedback cycle, `mod_sel` is high for the first A prescaler pulses and low for the rest. With A=0 it stays low.
- R6: `fb_div_pulse` is high for one clock, one clock after the B-th prescaler tick of a cycle. A feedback cycle spans exactly B prescaler pulses and P*B + A input cycles.
- R7: The reference divider raises `ref_div_pulse` for one clock, one clock after every R-th `ref_tick`. A limit of 0 or 1 passes every tick. A reference-limit load restarts the count.
- R8: With positive polarity, a divided reference pulse arriving alone raises `pump_up`, and a feedback pulse arriving alone raises `pump_dn`. Once the other pulse arrives, both outputs are low. Pulses arriving in the same clock raise neither. With negative polarity, the roles of the two outputs swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock tick per reference cycle |
| pre_tick | input | 1 | One-clock tick per prescaler output pulse |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Serial latch strobe, applied on its rising edge |
| mod_sel | output | 1 | Modulus request: 1 asks for P+1, 0 asks for P |
| presc_hi | output | 1 | Base modulus select: 0 for 16, 1 for 32 |
| ref_div_pulse | output | 1 | Divided reference pulse |
| fb_div_pulse | output | 1 | Divided feedback pulse |
| pump_up | output | 1 | Pump source request |
| pump_dn | output | 1 | Pump sink request |
| pump_level | output | 2 | Pump current code |
| n_load_err | output | 1 | Last feedback word was refused |

## Verification
The serial pins pass through one capture stage. A word's value therefore appears at the outputs two clocks after `ser_le` rises. The bench only reads settings after the strobe has fallen again.

A tick applied before a rising edge shows up on `ref_div_pulse` or `fb_div_pulse` at the next falling edge. The pump outputs react one clock later, so the detector checks are placed at exactly the second and third falling edge after a tick.

Division ratios are measured against a bench prescaler model. This model spends one clock per input cycle and reads `mod_sel` at the start of each prescaler period. The model's period comes from `presc_hi`, while the expected ratio comes from the value the bench loaded. The first feedback cycle after a load is skipped, and the next full cycle is compared with P*B + A.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_REF  = 2'b00,
        ADDR_FBN  = 2'b01,
        ADDR_CTL  = 2'b10,
        ADDR_NONE = 2'b11
    } addr_e;

    // control word payload, LSB is the base modulus select
    typedef struct packed {
        logic       pol_pos;
        logic [1:0] level;
        logic       p_hi;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/pswl_serial_if.sv
module pswl_serial_if
    import pswl_pkg::*;
#(
    parameter int R_W = 14,
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_le,
    output logic [R_W-1:0] r_lim,
    output logic [A_W-1:0] a_lim,
    output logic [B_W-1:0] b_lim,
    output ctl_t           ctl,
    output logic           r_load,
    output logic           n_load,
    output logic           n_err
);

    localparam int N_W   = A_W + B_W;
    localparam int MX1   = (R_W > N_W) ? R_W : N_W;
    localparam int PAY_W = (MX1 > CTL_W) ? MX1 : CTL_W;
    localparam int WORD_W = PAY_W + ADDR_W;

    typedef struct packed {
        logic              sclk_s;
        logic              sclk_p;
        logic              data_s;
        logic              le_s;
        logic              le_p;
        logic [WORD_W-1:0] shreg;
        logic [R_W-1:0]    r;
        logic [A_W-1:0]    a;
        logic [B_W-1:0]    b;
        ctl_t              ctl;
        logic              err;
        logic              r_ld;
        logic              n_ld;
    } st_t;

    st_t q, d;
    logic le_rise;
    addr_e adr;
    logic [A_W-1:0] na;
    logic [B_W-1:0] nb;

    assign le_rise = q.le_s & ~q.le_p;
    assign adr     = addr_e'(q.shreg[WORD_W-1 -: ADDR_W]);
    assign na      = q.shreg[A_W-1:0];
    assign nb      = q.shreg[N_W-1:A_W];

    always_comb begin
        d        = q;
        d.r_ld   = 1'b0;
        d.n_ld   = 1'b0;
        d.sclk_s = ser_clk;
        d.sclk_p = q.sclk_s;
        d.data_s = ser_data;
        d.le_s   = ser_le;
        d.le_p   = q.le_s;
        if (q.sclk_s && !q.sclk_p) begin
            d.shreg = {q.shreg[WORD_W-2:0], q.data_s};
        end
        if (le_rise) begin
            case (adr)
                ADDR_REF: begin
                    d.r    = q.shreg[R_W-1:0];
                    d.r_ld = 1'b1;
                end
                ADDR_FBN: begin
                    if ((nb == '0) || (B_W'(na) > nb)) begin
                        d.err = 1'b1;
                    end else begin
                        d.a    = na;
                        d.b    = nb;
                        d.err  = 1'b0;
                        d.n_ld = 1'b1;
                    end
                end
                ADDR_CTL: begin
                    d.ctl = ctl_t'(q.shreg[CTL_W-1:0]);
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q             <= '0;
            q.r           <= R_W'(1);
            q.b           <= B_W'(1);
            q.ctl.pol_pos <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign r_lim  = q.r;
    assign a_lim  = q.a;
    assign b_lim  = q.b;
    assign ctl    = q.ctl;
    assign r_load = q.r_ld;
    assign n_load = q.n_ld;
    assign n_err  = q.err;

    // R2: settings move only at a latch strobe edge
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> ($stable(q.r) && $stable(q.a) && $stable(q.b) && $stable(q.ctl)));

    // R3: a refused feedback word leaves the counts untouched
    p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> ($stable(q.a) && $stable(q.b)));

endmodule

// File: rtl/pswl_ref_div.sv
module pswl_ref_div #(
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           restart,
    input  logic [R_W-1:0] r_lim,
    output logic           pulse
);

    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic           pls;
    } st_t;

    st_t q, d;
    logic term;

    assign term = (r_lim <= R_W'(1)) || (q.cnt >= r_lim - R_W'(1));

    always_comb begin
        d     = q;
        d.pls = 1'b0;
        if (restart) begin
            d.cnt = '0;
        end else if (tick) begin
            if (term) begin
                d.cnt = '0;
                d.pls = 1'b1;
            end else begin
                d.cnt = q.cnt + R_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pulse = q.pls;

    // R7: count stays inside the programmed range
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> ((r_lim <= R_W'(1)) ? (q.cnt == '0) : (q.cnt < r_lim)));

    // R7: a divided pulse always comes with a wrapped counter
    p_pulse_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.pls |-> (q.cnt == '0));

endmodule

// File: rtl/pswl_fb_div.sv
module pswl_fb_div #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           restart,
    input  logic [A_W-1:0] a_lim,
    input  logic [B_W-1:0] b_lim,
    output logic           mod_sel,
    output logic           pulse
);

    typedef struct packed {
        logic [A_W-1:0] a_cnt;
        logic [B_W-1:0] b_cnt;
        logic           pls;
    } st_t;

    st_t q, d;
    logic b_full;

    assign b_full = (q.b_cnt >= b_lim - B_W'(1));

    always_comb begin
        d     = q;
        d.pls = 1'b0;
        if (restart) begin
            d.a_cnt = '0;
            d.b_cnt = '0;
        end else if (tick) begin
            if (b_full) begin
                d.a_cnt = '0;
                d.b_cnt = '0;
                d.pls   = 1'b1;
            end else begin
                d.b_cnt = q.b_cnt + B_W'(1);
                if (q.a_cnt < a_lim) begin
                    d.a_cnt = q.a_cnt + A_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mod_sel = (q.a_cnt < a_lim);
    assign pulse   = q.pls;

    // R5: A is swallowed inside B, so it never runs ahead of it
    p_a_trails_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        B_W'(q.a_cnt) <= q.b_cnt);

    // R6: both counters restart together at the end of a cycle
    p_pulse_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.pls |-> ((q.a_cnt == '0) && (q.b_cnt == '0)));

endmodule

// File: rtl/pswl_pfd.sv
module pswl_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic fb_ev,
    input  logic pol_pos,
    output logic up,
    output logic dn
);

    typedef struct packed {
        logic lead_ref;
        logic lead_fb;
    } st_t;

    st_t q, d;
    logic r_hit, f_hit;

    assign r_hit = q.lead_ref | ref_ev;
    assign f_hit = q.lead_fb | fb_ev;

    always_comb begin
        d = q;
        if (r_hit && f_hit) begin
            d.lead_ref = 1'b0;
            d.lead_fb  = 1'b0;
        end else begin
            d.lead_ref = r_hit;
            d.lead_fb  = f_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign up = pol_pos ? q.lead_ref : q.lead_fb;
    assign dn = pol_pos ? q.lead_fb  : q.lead_ref;

    // R8: never both sides active
    p_tristate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.lead_ref && q.lead_fb));

    // R8: the lagging edge resets the detector
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lead_ref && fb_ev) |=> (!q.lead_ref && !q.lead_fb));

endmodule

// File: rtl/pswl_synth_div.sv
module pswl_synth_div
    import pswl_pkg::*;
#(
    parameter int R_W = 14,
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       pre_tick,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_le,
    output logic       mod_sel,
    output logic       presc_hi,
    output logic       ref_div_pulse,
    output logic       fb_div_pulse,
    output logic       pump_up,
    output logic       pump_dn,
    output logic [1:0] pump_level,
    output logic       n_load_err
);

    logic [R_W-1:0] r_lim;
    logic [A_W-1:0] a_lim;
    logic [B_W-1:0] b_lim;
    ctl_t           ctl;
    logic           r_load;
    logic           n_load;

    pswl_serial_if #(.R_W(R_W), .A_W(A_W), .B_W(B_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_data(ser_data),
        .ser_le  (ser_le),
        .r_lim   (r_lim),
        .a_lim   (a_lim),
        .b_lim   (b_lim),
        .ctl     (ctl),
        .r_load  (r_load),
        .n_load  (n_load),
        .n_err   (n_load_err)
    );

    pswl_ref_div #(.R_W(R_W)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ref_tick),
        .restart(r_load),
        .r_lim  (r_lim),
        .pulse  (ref_div_pulse)
    );

    pswl_fb_div #(.A_W(A_W), .B_W(B_W)) u_fb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (pre_tick),
        .restart(n_load),
        .a_lim  (a_lim),
        .b_lim  (b_lim),
        .mod_sel(mod_sel),
        .pulse  (fb_div_pulse)
    );

    pswl_pfd u_pfd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_ev (ref_div_pulse),
        .fb_ev  (fb_div_pulse),
        .pol_pos(ctl.pol_pos),
        .up     (pump_up),
        .dn     (pump_dn)
    );

    assign presc_hi   = ctl.p_hi;
    assign pump_level = ctl.level;

endmodule

// File: tb/pswl_synth_div_bench.sv
module pswl_synth_div_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, ref_tick, ser_clk, ser_data, ser_le;
    logic pre_model, man_pre, pre_auto;
    logic pre_tick;
    logic mod_sel, presc_hi, ref_div_pulse, fb_div_pulse, pump_up, pump_dn, n_load_err;
    logic [1:0] pump_level;

    assign pre_tick = pre_auto ? pre_model : man_pre;

    pswl_synth_div u_pswl_synth_div (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pre_tick(pre_tick),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .mod_sel(mod_sel), .presc_hi(presc_hi), .ref_div_pulse(ref_div_pulse),
        .fb_div_pulse(fb_div_pulse), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_level(pump_level), .n_load_err(n_load_err)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0, fb_t = 0, fb_seen = 0;
    int last_period = 0, last_pulses = 0, last_mod = 0;
    int npul = 0, nmod = 0, pcnt = 0, plen = 0;
    bit mod_cur = 1'b0;
    int exp_p = 16;

    task automatic report;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // prescaler model: one clock per input cycle, modulus read at period start
    always @(negedge clk) begin
        cyc++;
        if (fb_div_pulse) begin
            last_period = cyc - fb_t;
            fb_t        = cyc;
            last_pulses = npul;
            last_mod    = nmod;
            npul        = 0;
            nmod        = 0;
            fb_seen++;
        end
        if (!pre_auto) begin
            pcnt      = 0;
            pre_model = 1'b0;
        end else begin
            if (pcnt == 0) begin
                mod_cur = mod_sel;
                plen    = (presc_hi ? 32 : 16) + (mod_sel ? 1 : 0);
            end
            pcnt++;
            if (pcnt == plen) begin
                pre_model = 1'b1;
                pcnt      = 0;
                npul++;
                if (mod_cur) nmod++;
            end else begin
                pre_model = 1'b0;
            end
        end
    end

    task automatic send_word(logic [1:0] adr, logic [18:0] pay);
        logic [20:0] w;
        w = {adr, pay};
        for (int i = 20; i >= 0; i--) begin
            @(negedge clk) ser_data = w[i];
            @(negedge clk) ser_clk = 1'b1;
            @(negedge clk);
            @(negedge clk) ser_clk = 1'b0;
        end
        @(negedge clk) ser_le = 1'b1;
        repeat (3) @(negedge clk);
        ser_le = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic load_ctl(bit hi, int lvl, bit pos);
        send_word(2'b10, {15'd0, pos, 2'(lvl), hi});
        exp_p = hi ? 32 : 16;
    endtask

    task automatic load_n(int a, int b);
        send_word(2'b01, {13'(b), 6'(a)});
    endtask

    task automatic wait_fb(int k);
        int s;
        s = fb_seen;
        while (fb_seen < s + k) @(negedge clk);
    endtask

    task automatic measure(int a, int b);
        wait_fb(2);
        chk("R6 period", last_period, exp_p * b + a);
        chk("R6 pulses per cycle", last_pulses, b);
        chk("R5 pulses with mod_sel high", last_mod, a);
    endtask

    task automatic run_cfg(bit hi, int a, int b);
        int lvl;
        lvl = int'($urandom_range(3, 0));
        load_ctl(hi, lvl, 1'b1);
        chk("R4 pump_level", int'(pump_level), lvl);
        chk("R4 presc_hi", int'(presc_hi), int'(hi));
        load_n(a, b);
        chk("R3 accepted word clears flag", int'(n_load_err), 0);
        measure(a, b);
    endtask

    task automatic tick_ref(output int got);
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
        got = int'(ref_div_pulse);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        report();
        $finish;
    end

    initial begin
        int got;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ref_tick = 1'b0; ser_clk = 1'b0; ser_data = 1'b0;
        ser_le = 1'b0; man_pre = 1'b0; pre_auto = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 mod_sel", int'(mod_sel), 0);
        chk("R1 presc_hi", int'(presc_hi), 0);
        chk("R1 pump_level", int'(pump_level), 0);
        chk("R1 pumps", int'({pump_up, pump_dn}), 0);
        chk("R1 pulses", int'({ref_div_pulse, fb_div_pulse}), 0);
        chk("R1 n_load_err", int'(n_load_err), 0);

        // R1: default B=1, A=0, P=16 divides by 16
        pre_auto = 1'b1;
        measure(0, 1);

        // directed corners for R5 and R6
        run_cfg(1'b0, 0, 7);
        run_cfg(1'b1, 5, 5);
        run_cfg(1'b1, 0, 1);
        run_cfg(1'b0, 63, 63);

        // random configurations
        for (int it = 0; it < 6; it++) begin
            int b, a;
            b = int'($urandom_range(12, 1));
            a = int'($urandom_range(b, 0));
            run_cfg(1'($urandom_range(1, 0)), a, b);
        end

        // R3: refused words keep the old counts
        load_ctl(1'b0, 2, 1'b1);
        load_n(3, 6);
        measure(3, 6);
        load_n(9, 4);
        chk("R3 A>B flagged", int'(n_load_err), 1);
        measure(3, 6);
        load_n(0, 0);
        chk("R3 B=0 flagged", int'(n_load_err), 1);
        measure(3, 6);
        load_n(2, 4);
        chk("R3 flag cleared", int'(n_load_err), 0);
        measure(2, 4);

        // R2: address 11 is discarded
        send_word(2'b11, {13'd2, 6'd7});
        chk("R2 discarded word keeps level", int'(pump_level), 2);
        chk("R2 discarded word keeps modulus", int'(presc_hi), 0);
        measure(2, 4);

        // R7: reference divider
        pre_auto = 1'b0;
        send_word(2'b00, 19'd5);
        for (int k = 1; k <= 10; k++) begin
            tick_ref(got);
            chk("R7 divide by 5", got, (k % 5 == 0) ? 1 : 0);
            @(negedge clk);
        end
        send_word(2'b00, 19'd0);
        for (int k = 0; k < 3; k++) begin
            tick_ref(got);
            chk("R7 limit 0 passes every tick", got, 1);
            @(negedge clk);
        end

        // R8: detector, after a fresh reset (R=1, B=1, A=0, positive)
        do_reset();
        tick_ref(got);
        chk("R1 default R passes tick", got, 1);
        @(negedge clk);
        chk("R8 ref alone raises up", int'(pump_up), 1);
        chk("R8 ref alone keeps dn low", int'(pump_dn), 0);
        man_pre = 1'b1;
        @(negedge clk) man_pre = 1'b0;
        chk("R8 up held until fb", int'(pump_up), 1);
        @(negedge clk);
        chk("R8 both cleared", int'({pump_up, pump_dn}), 0);

        man_pre = 1'b1;
        @(negedge clk) man_pre = 1'b0;
        @(negedge clk);
        chk("R8 fb alone raises dn", int'(pump_dn), 1);
        chk("R8 fb alone keeps up low", int'(pump_up), 0);
        tick_ref(got);
        @(negedge clk);
        chk("R8 cleared after ref", int'({pump_up, pump_dn}), 0);

        ref_tick = 1'b1; man_pre = 1'b1;
        @(negedge clk) begin ref_tick = 1'b0; man_pre = 1'b0; end
        @(negedge clk);
        chk("R8 simultaneous gives nothing", int'({pump_up, pump_dn}), 0);
        @(negedge clk);
        chk("R8 simultaneous stays quiet", int'({pump_up, pump_dn}), 0);

        load_ctl(1'b0, 0, 1'b0);
        tick_ref(got);
        @(negedge clk);
        chk("R8 negative polarity ref raises dn", int'(pump_dn), 1);
        chk("R8 negative polarity up low", int'(pump_up), 0);
        man_pre = 1'b1;
        @(negedge clk) man_pre = 1'b0;
        @(negedge clk);
        chk("R8 negative polarity cleared", int'({pump_up, pump_dn}), 0);

        report();
        $finish;
    end

endmodule